// File: doc/BRIEF.md
# Nine-Bit Multidrop Serial Port with Address Filtering

This block is a serial transmitter and receiver for shared multidrop lines. Every character on the line carries nine data bits. The top bit is a tag: 1 means the character is a station address, and 0 means it is payload. Several stations listen on one line. Each receiver keeps only the payload that follows its own address and drops everything else.

On the receive side, each address character is compared with a programmable station address. A match opens the gate for the payload characters that follow, so they go into a small show-ahead FIFO. A mismatch closes the gate. A match also sets a sticky status flag.

On the transmit side there are two modes.
- Automatic mode: a stored destination address is sent by hardware, as a tagged character, ahead of the first payload character written after that address was loaded.
- Raw mode: the caller supplies the tag bit with every character.

Bit timing comes from a 16x oversampling tick at clock / divisor.

Top module: `mdrop_uart`

## Requirements
- R1: After reset, `txd` is high, `tx_ready` is 1, `rx_valid` is 0, `rx_level` is 0, and `addr_seen` and `frame_err` are 0.
- R2: A frame is sent and received in this order: one low start bit, data bits 0..7 LSB first, then the tag as bit 8, then one high stop bit. Each bit lasts 16 × `divisor` clock cycles. The line is high whenever `tx_ready` is 1.
- R3: With `tx_mode` = 1, each accepted character goes out with the tag taken from `tx_ninth`.
- R4: With `tx_mode` = 0, a pulse on `tx_addr_we` stores `tx_addr` and arms it. The next accepted character is preceded by a frame carrying that address with tag 1. Payload frames carry tag 0 whatever `tx_ninth` is. Later characters get no address frame until the next `tx_addr_we`.
- R5: After a received address character with tag 1 that equals `rx_addr`, each payload character (tag 0) is written to the FIFO. Payload is read out in arrival order on `rx_data` while `rx_valid` is 1, and `rx_pop` removes the head.
- R6: An address character that differs from `rx_addr` closes the gate, and payload is discarded until a matching address arrives. The gate is closed after reset.
- R7: A matching address sets `addr_seen`, which stays set until `status_clr`. A non-matching address leaves it clear.
- R8: A stop bit sampled low sets the sticky `frame_err` (cleared by `status_clr`), and that character is neither stored nor used as an address.
- R9: The FIFO holds `FIFO_DEPTH` (at most 16) entries. Payload arriving while it is full is dropped, and `rx_level` reports the fill count.
- R10: Address characters themselves are never written to the FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| divisor | input | DIV_W | Clocks per oversampling tick (0 acts as 1) |
| tx_mode | input | 1 | 0 = automatic address insertion, 1 = raw tag per character |
| tx_addr_we | input | 1 | Stores `tx_addr` and arms an address frame |
| tx_addr | input | 8 | Destination address for automatic mode |
| tx_valid | input | 1 | Character offered for transmission |
| tx_data | input | 8 | Character payload |
| tx_ninth | input | 1 | Tag bit used in raw mode |
| tx_ready | output | 1 | Transmitter accepts a character this cycle |
| txd | output | 1 | Serial output, idle high |
| rxd | input | 1 | Serial input, idle high |
| rx_addr | input | 8 | This station's address |
| rx_pop | input | 1 | Removes the FIFO head |
| rx_valid | output | 1 | FIFO not empty |
| rx_data | output | 8 | FIFO head |
| rx_level | output | LVL_W | FIFO fill count |
| addr_seen | output | 1 | Sticky: matching address received |
| frame_err | output | 1 | Sticky: stop bit sampled low |
| status_clr | input | 1 | Clears `addr_seen` and `frame_err` |

## Verification
A gate left in the wrong state shows at the ports within one frame. Payload meant for this station is then missing from `rx_valid`/`rx_data`, or foreign payload appears there, and so does an address byte that was wrongly stored. The scoreboard catches this at the first pop. A transmitter with a wrong tag, bit order or bit period gives a mis-decoded character on `txd` at the next frame. A lost or stale armed address shows as a missing or extra tagged frame ahead of the payload. A misrouted error or status path shows on the sticky flags as soon as the affected stop bit has been sampled.

// File: rtl/mdrop_pkg.sv
package mdrop_pkg;
    localparam int OSR        = 16;
    localparam int CHAR_BITS  = 9;
    localparam int FRAME_BITS = CHAR_BITS + 2;

    typedef struct packed {
        logic       tag;
        logic [7:0] byte_v;
    } char9_t;

    typedef enum logic [1:0] {
        RX_IDLE, RX_START, RX_BITS, RX_STOP
    } rx_state_e;

    // Bit 0 leaves first: start, byte LSB first, tag, stop.
    function automatic logic [FRAME_BITS-1:0] frame_of(char9_t c);
        return {1'b1, c, 1'b0};
    endfunction
endpackage

// File: rtl/mdrop_baud.sv
module mdrop_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] lim;

    assign lim  = (divisor == '0) ? '0 : divisor - 1'b1;
    assign tick = (cnt >= lim);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/mdrop_tx.sv
module mdrop_tx
    import mdrop_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       tx_mode,
    input  logic       tx_addr_we,
    input  logic [7:0] tx_addr,
    input  logic       tx_valid,
    input  logic [7:0] tx_data,
    input  logic       tx_ninth,
    output logic       tx_ready,
    output logic       txd
);
    logic [FRAME_BITS-1:0] shreg;
    logic                  busy;
    logic [3:0]            bitn;
    logic [3:0]            tickn;
    logic [7:0]            addr_reg;
    logic                  addr_pend;
    char9_t                hold;
    logic                  hold_v;

    logic   load_en;
    char9_t load_c;
    logic   stash;

    assign tx_ready = !busy && !hold_v;
    assign txd      = shreg[0];

    always_comb begin
        load_en = 1'b0;
        stash   = 1'b0;
        load_c  = '0;
        if (!busy && hold_v) begin
            load_en = 1'b1;
            load_c  = hold;
        end else if (!busy && tx_valid) begin
            load_en = 1'b1;
            if (!tx_mode && addr_pend) begin
                load_c = '{tag: 1'b1, byte_v: addr_reg};
                stash  = 1'b1;
            end else begin
                load_c = '{tag: tx_mode & tx_ninth, byte_v: tx_data};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg     <= '1;
            busy      <= 1'b0;
            bitn      <= '0;
            tickn     <= '0;
            addr_reg  <= '0;
            addr_pend <= 1'b0;
            hold      <= '0;
            hold_v    <= 1'b0;
        end else begin
            if (load_en) begin
                shreg  <= frame_of(load_c);
                busy   <= 1'b1;
                bitn   <= '0;
                tickn  <= '0;
                hold_v <= stash;
                if (stash) begin
                    hold      <= '{tag: 1'b0, byte_v: tx_data};
                    addr_pend <= 1'b0;
                end
            end else if (busy && tick) begin
                if (tickn == 4'(OSR - 1)) begin
                    tickn <= '0;
                    shreg <= {1'b1, shreg[FRAME_BITS-1:1]};
                    if (bitn == 4'(FRAME_BITS - 1)) busy <= 1'b0;
                    else                            bitn <= bitn + 1'b1;
                end else begin
                    tickn <= tickn + 1'b1;
                end
            end
            if (tx_addr_we) begin
                addr_reg  <= tx_addr;
                addr_pend <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/mdrop_rx.sv
module mdrop_rx
    import mdrop_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       rxd,
    input  logic [7:0] rx_addr,
    input  logic       status_clr,
    output logic       push,
    output logic [7:0] push_data,
    output logic       addr_seen,
    output logic       frame_err
);
    logic      s1, s2;
    rx_state_e state;
    logic [3:0] tickn;
    logic [3:0] bitn;
    char9_t     shift;
    logic       admit;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1        <= 1'b1;
            s2        <= 1'b1;
            state     <= RX_IDLE;
            tickn     <= '0;
            bitn      <= '0;
            shift     <= '0;
            admit     <= 1'b0;
            push      <= 1'b0;
            push_data <= '0;
            addr_seen <= 1'b0;
            frame_err <= 1'b0;
        end else begin
            s1   <= rxd;
            s2   <= s1;
            push <= 1'b0;
            if (status_clr) begin
                addr_seen <= 1'b0;
                frame_err <= 1'b0;
            end
            if (tick) begin
                unique case (state)
                    RX_IDLE: if (!s2) begin
                        state <= RX_START;
                        tickn <= '0;
                    end
                    RX_START: begin
                        if (tickn == 4'(OSR/2 - 1)) begin
                            tickn <= '0;
                            bitn  <= '0;
                            state <= s2 ? RX_IDLE : RX_BITS;
                        end else begin
                            tickn <= tickn + 1'b1;
                        end
                    end
                    RX_BITS: begin
                        if (tickn == 4'(OSR - 1)) begin
                            tickn <= '0;
                            shift <= {s2, shift[CHAR_BITS-1:1]};
                            if (bitn == 4'(CHAR_BITS - 1)) state <= RX_STOP;
                            else                           bitn  <= bitn + 1'b1;
                        end else begin
                            tickn <= tickn + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        if (tickn == 4'(OSR - 1)) begin
                            tickn <= '0;
                            state <= RX_IDLE;
                            if (!s2) begin
                                frame_err <= 1'b1;
                            end else if (shift.tag) begin
                                admit <= (shift.byte_v == rx_addr);
                                if (shift.byte_v == rx_addr) addr_seen <= 1'b1;
                            end else if (admit) begin
                                push      <= 1'b1;
                                push_data <= shift.byte_v;
                            end
                        end else begin
                            tickn <= tickn + 1'b1;
                        end
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/mdrop_fifo.sv
module mdrop_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 8,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic          valid,
    output logic [W-1:0]  rdata,
    output logic [LW-1:0] level
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic          do_w, do_r;

    assign valid = (level != '0);
    assign rdata = mem[rp];
    assign do_w  = push && (level != LW'(DEPTH));
    assign do_r  = pop && valid;

    always_ff @(posedge clk) begin
        if (do_w) mem[wp] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (do_w) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_r) rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            if (do_w && !do_r)      level <= level + 1'b1;
            else if (do_r && !do_w) level <= level - 1'b1;
        end
    end
endmodule

// File: rtl/mdrop_uart.sv
module mdrop_uart #(
    parameter int DIV_W      = 16,
    parameter int FIFO_DEPTH = 8,
    localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] divisor,
    input  logic             tx_mode,
    input  logic             tx_addr_we,
    input  logic [7:0]       tx_addr,
    input  logic             tx_valid,
    input  logic [7:0]       tx_data,
    input  logic             tx_ninth,
    output logic             tx_ready,
    output logic             txd,
    input  logic             rxd,
    input  logic [7:0]       rx_addr,
    input  logic             rx_pop,
    output logic             rx_valid,
    output logic [7:0]       rx_data,
    output logic [LVL_W-1:0] rx_level,
    output logic             addr_seen,
    output logic             frame_err,
    input  logic             status_clr
);
    logic       tick;
    logic       push;
    logic [7:0] push_data;

    mdrop_baud #(.DIV_W(DIV_W)) baud_i (
        .clk(clk), .rst(rst), .divisor(divisor), .tick(tick)
    );

    mdrop_tx tx_i (
        .clk(clk), .rst(rst), .tick(tick), .tx_mode(tx_mode),
        .tx_addr_we(tx_addr_we), .tx_addr(tx_addr), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_ninth(tx_ninth), .tx_ready(tx_ready), .txd(txd)
    );

    mdrop_rx rx_i (
        .clk(clk), .rst(rst), .tick(tick), .rxd(rxd), .rx_addr(rx_addr),
        .status_clr(status_clr), .push(push), .push_data(push_data),
        .addr_seen(addr_seen), .frame_err(frame_err)
    );

    mdrop_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) fifo_i (
        .clk(clk), .rst(rst), .push(push), .wdata(push_data), .pop(rx_pop),
        .valid(rx_valid), .rdata(rx_data), .level(rx_level)
    );
endmodule

// File: rtl/mdrop_uart_chk.sv
module mdrop_uart_chk #(
    parameter int DEPTH = 8,
    parameter int LVL_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             tx_ready,
    input logic             txd,
    input logic             rx_pop,
    input logic [LVL_W-1:0] rx_level,
    input logic             addr_seen,
    input logic             frame_err,
    input logic             status_clr
);
    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
        tx_ready |-> txd);                                              // R2
    AST_NO_LOSS_WITHOUT_POP: assert property (@(posedge clk) disable iff (rst)
        !rx_pop |=> (rx_level >= $past(rx_level)));                     // R5
    AST_ADDR_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (addr_seen && !status_clr) |=> addr_seen);                      // R7
    AST_FERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (frame_err && !status_clr) |=> frame_err);                      // R8
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        rx_level <= LVL_W'(DEPTH));                                     // R9
endmodule

bind mdrop_uart mdrop_uart_chk #(.DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) chk_i (
    .clk(clk), .rst(rst), .tx_ready(tx_ready), .txd(txd), .rx_pop(rx_pop),
    .rx_level(rx_level), .addr_seen(addr_seen), .frame_err(frame_err),
    .status_clr(status_clr)
);

// File: tb/mdrop_uart_tb_top.sv
module mdrop_uart_tb_top;
    localparam int DIV   = 4;
    localparam int DEPTH = 8;
    localparam int BITC  = 16 * DIV;
    localparam int LW    = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst = 1'b1;
    logic [15:0]   divisor = 16'(DIV);
    logic          tx_mode = 1'b1, tx_addr_we = 1'b0, tx_valid = 1'b0, tx_ninth = 1'b0;
    logic [7:0]    tx_addr = '0, tx_data = '0, rx_addr = 8'h5A;
    logic          tx_ready, txd, rx_valid, addr_seen, frame_err;
    logic          rxd = 1'b1, rx_pop = 1'b0, status_clr = 1'b0;
    logic [7:0]    rx_data;
    logic [LW-1:0] rx_level;

    mdrop_uart #(.DIV_W(16), .FIFO_DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst(rst), .divisor(divisor), .tx_mode(tx_mode),
        .tx_addr_we(tx_addr_we), .tx_addr(tx_addr), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_ninth(tx_ninth), .tx_ready(tx_ready), .txd(txd),
        .rxd(rxd), .rx_addr(rx_addr), .rx_pop(rx_pop), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_level(rx_level), .addr_seen(addr_seen),
        .frame_err(frame_err), .status_clr(status_clr)
    );

    int checks = 0, fails = 0;
    bit done = 0, mon_en = 1;
    logic [8:0] exp_tx[$];
    logic [7:0] exp_rx[$];

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Serial driver into rxd; a bad stop is held low briefly, then released.
    task automatic send_rx(logic [8:0] c, bit good_stop);
        rxd = 1'b0;
        repeat (BITC) @(negedge clk);
        for (int i = 0; i < 9; i++) begin
            rxd = c[i];
            repeat (BITC) @(negedge clk);
        end
        if (good_stop) begin
            rxd = 1'b1;
            repeat (BITC) @(negedge clk);
        end else begin
            rxd = 1'b0;
            repeat (10 * DIV) @(negedge clk);
            rxd = 1'b1;
        end
        repeat (2 * BITC) @(negedge clk);
    endtask

    task automatic tx_send(logic [7:0] d, logic nin);
        @(negedge clk);
        while (!tx_ready) @(negedge clk);
        tx_data  = d;
        tx_ninth = nin;
        tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic drain(string req);
        int t = 0;
        while ((exp_tx.size() != 0 || exp_rx.size() != 0) && t < 40000) begin
            @(negedge clk);
            t++;
        end
        repeat (4 * BITC) @(negedge clk);
        chk(exp_tx.size() == 0 && exp_rx.size() == 0, req,
            exp_tx.size() + exp_rx.size(), 0);
    endtask

    // Receive monitor: pops the FIFO and compares against the scoreboard.
    always @(negedge clk) begin
        rx_pop = 1'b0;
        if (!rst && mon_en && rx_valid) begin
            if (exp_rx.size() == 0) begin
                chk(1'b0, "R5/R6/R10 unexpected byte", rx_data, 0);
            end else begin
                automatic logic [7:0] e = exp_rx.pop_front();
                chk(rx_data == e, "R5 order/content", rx_data, e);
            end
            rx_pop = 1'b1;
        end
    end

    // Transmit monitor: decodes frames on txd at the nominal bit period.
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && txd == 1'b0) begin
                automatic logic [8:0] got = '0;
                repeat (BITC / 2) @(negedge clk);
                chk(txd == 1'b0, "R2 start bit", txd, 0);
                for (int i = 0; i < 9; i++) begin
                    repeat (BITC) @(negedge clk);
                    got[i] = txd;
                end
                repeat (BITC) @(negedge clk);
                chk(txd == 1'b1, "R2 stop bit", txd, 1);
                if (exp_tx.size() == 0) begin
                    chk(1'b0, "R3/R4 unexpected frame", got, 0);
                end else begin
                    automatic logic [8:0] e = exp_tx.pop_front();
                    chk(got == e, "R2/R3/R4 frame", got, e);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(txd == 1'b1, "R1 txd", txd, 1);
        chk(tx_ready == 1'b1, "R1 tx_ready", tx_ready, 1);
        chk(rx_valid == 1'b0 && rx_level == 0, "R1 fifo empty", rx_level, 0);
        chk(addr_seen == 1'b0 && frame_err == 1'b0, "R1 flags", {addr_seen, frame_err}, 0);

        // R6: payload before any address is discarded
        send_rx(9'h011, 1'b1);
        chk(rx_level == 0, "R6 gate closed after reset", rx_level, 0);

        // R6/R7: foreign address, payload dropped, flag stays clear
        send_rx(9'h122, 1'b1);
        send_rx(9'h033, 1'b1);
        chk(rx_level == 0, "R6 foreign payload dropped", rx_level, 0);
        chk(addr_seen == 1'b0, "R7 no flag on mismatch", addr_seen, 0);

        // R5/R10/R7: matching address opens gate
        exp_rx.push_back(8'hA1); exp_rx.push_back(8'h3C); exp_rx.push_back(8'hFF);
        send_rx(9'h15A, 1'b1);
        chk(addr_seen == 1'b1, "R7 flag on match", addr_seen, 1);
        send_rx(9'h0A1, 1'b1);
        send_rx(9'h03C, 1'b1);
        send_rx(9'h0FF, 1'b1);
        drain("R5 all payload delivered");

        @(negedge clk); status_clr = 1'b1;
        @(negedge clk); status_clr = 1'b0;
        chk(addr_seen == 1'b0, "R7 cleared", addr_seen, 0);

        // R6: gate closes on mismatch, reopens on match
        send_rx(9'h110, 1'b1);
        send_rx(9'h077, 1'b1);
        chk(rx_level == 0, "R6 closed by mismatch", rx_level, 0);
        exp_rx.push_back(8'h42);
        send_rx(9'h15A, 1'b1);
        send_rx(9'h042, 1'b1);
        drain("R6 reopened by match");

        // R8: bad stop bit
        send_rx(9'h099, 1'b0);
        chk(frame_err == 1'b1, "R8 frame_err set", frame_err, 1);
        chk(rx_level == 0, "R8 bad char not stored", rx_level, 0);
        exp_rx.push_back(8'h55);
        send_rx(9'h055, 1'b1);
        drain("R8 next char ok");

        // R9: overflow drops extra payload
        mon_en = 0;
        for (int i = 0; i < DEPTH + 2; i++) begin
            if (i < DEPTH) exp_rx.push_back(8'(8'h60 + i));
            send_rx(9'(8'h60 + i), 1'b1);
        end
        chk(rx_level == LW'(DEPTH), "R9 level saturates", rx_level, DEPTH);
        mon_en = 1;
        drain("R9 first DEPTH kept");

        // R3: raw mode, tag per character
        tx_mode = 1'b1;
        exp_tx.push_back(9'h15A); exp_tx.push_back(9'h012); exp_tx.push_back(9'h0F0);
        tx_send(8'h5A, 1'b1);
        tx_send(8'h12, 1'b0);
        tx_send(8'hF0, 1'b0);
        drain("R3 raw frames sent");

        // R4: automatic address insertion
        tx_mode = 1'b0;
        @(negedge clk); tx_addr = 8'h3C; tx_addr_we = 1'b1;
        @(negedge clk); tx_addr_we = 1'b0;
        exp_tx.push_back(9'h13C); exp_tx.push_back(9'h081); exp_tx.push_back(9'h07E);
        tx_send(8'h81, 1'b1);
        tx_send(8'h7E, 1'b1);
        drain("R4 address then payload");
        exp_tx.push_back(9'h001);
        tx_send(8'h01, 1'b0);
        drain("R4 no repeat address");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule